// File: doc/BRIEF.md
# Receive Elasticity Buffer with SKP Compensation

This block sits between a recovered receive clock and the local parallel clock of a SuperSpeed-style receiver. Decoded 8-bit symbols arrive one per write-clock cycle. Each symbol carries a control flag and two error tags, one for a decode error and one for a disparity error. The block stores them in a small ring. In the parallel-clock domain it hands them out two at a time on a 16-bit bus, with a 3-bit status code for every pair. The write clock is expected to run at about twice the parallel-clock rate. The parallel clock is nominally 250 MHz.

Small frequency differences between the two clocks are absorbed at SKP ordered sets. A SKP symbol (control flag 1, value 8'h3C) is dropped on the write side when the buffer runs too full. A SKP is emitted twice on the read side when the buffer runs too empty. The `empty_mode` input selects the fill point that the buffer steers towards. At 0 that point is half the depth; at 1 it is a small fixed level (`NOM_EMPTY`). `empty_mode` is treated as static and may change only while both resets are asserted.

The input side follows a valid-only stream rule. A recovered line stream cannot be paused, so there is no ready signal. A symbol presented with `in_valid` high is always taken or counted as lost. Lost symbols are reported as an overflow status, never as back-pressure. The output side is also valid-only: the link layer must accept every pair presented with `rx_valid` high.

Top module: `rx_elastic_buf`

## Requirements
- R1: Each valid output pair places the earlier symbol in `rx_data[7:0]` and the later one in `rx_data[15:8]`. `rx_ctrl[0]` and `rx_ctrl[1]` give the matching control flags (0 = data, 1 = control). Every non-SKP input symbol appears exactly once, in arrival order.
- R2: `rx_valid` stays low until the read-side fill reaches the nominal level: `DEPTH/2` when `empty_mode`=0, or `NOM_EMPTY` when `empty_mode`=1. While `rx_valid` is low, `rx_data` and `rx_ctrl` are zero.
- R3: `rx_status` uses these codes: 000 ok, 001 SKP added, 010 SKP removed, 100 decode error, 101 overflow, 110 underflow, 111 disparity error. When several apply to one pair, the order of precedence is decode, disparity, overflow, underflow, added, removed.
- R4: An incoming SKP is discarded when the write-side fill exceeds nominal plus `THR`. At most one SKP is discarded per ordered set. The pair carrying the next stored symbol reports 010.
- R5: With `empty_mode`=0, a SKP is sent out twice when the read-side fill plus `THR` is below nominal. At most one SKP is repeated per ordered set. That pair is valid and reports 001.
- R6: With `empty_mode`=0, if fewer than two symbols are buffered while locked, the block reports 110 with `rx_valid` low and relocks at nominal. With `empty_mode`=1, 110 never appears: that cycle simply has `rx_valid` low and lock is kept.
- R7: A symbol that arrives while the buffer is full is discarded. The pair carrying the next stored symbol reports 101. The buffer is then flushed, and `rx_valid` stays low until the fill has grown back to nominal.
- R8: While reset is asserted, `rx_valid`, `rx_data`, `rx_ctrl` and `rx_status` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered symbol clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| in_valid | input | 1 | A symbol is presented this write cycle |
| in_sym | input | 8 | Decoded symbol value |
| in_ctrl | input | 1 | Control flag of the symbol (1 = control) |
| in_dec_err | input | 1 | Symbol failed decoding |
| in_disp_err | input | 1 | Symbol had a running-disparity error |
| pclk | input | 1 | Parallel output clock |
| p_rst_n | input | 1 | Active-low asynchronous reset, parallel domain |
| empty_mode | input | 1 | 0: steer to half full, 1: steer to nearly empty |
| rx_data | output | 16 | Two symbols, earlier one in the low byte |
| rx_ctrl | output | 2 | Control flags for the low and high bytes |
| rx_valid | output | 1 | Lock held and the pair is valid |
| rx_status | output | 3 | Status code for this pair |

## Verification
The assertions assume that `empty_mode` holds still outside reset and that both resets are released together. They also assume that the write clock stays close to twice the parallel clock, apart from deliberate overload. The stimulus changes the mode only inside reset. It sends SKP sets of four symbols every 36 symbols, so that a whole set never fits inside one synchronizer delay. It places error tags so that a decode tag and a disparity tag never land on neighbouring symbols, except on purpose. Write-clock drift is kept to about one percent, except in the phase that forces an overflow.

// File: rtl/rxeb_pkg.sv
`timescale 1ns/1ps
package rxeb_pkg;

  // One buffered symbol plus the events that travel with it.
  typedef struct packed {
    logic       ovf;   // symbols were lost just before this one
    logic       rm;    // a SKP was discarded just before this one
    logic       dec;
    logic       disp;
    logic       ctrl;
    logic [7:0] sym;
  } slot_t;

  typedef enum logic [2:0] {
    ST_OK   = 3'b000,
    ST_ADD  = 3'b001,
    ST_DEL  = 3'b010,
    ST_DEC  = 3'b100,
    ST_OVF  = 3'b101,
    ST_UNF  = 3'b110,
    ST_DISP = 3'b111
  } rx_stat_e;

  // Precedence among events that coincide on one output pair.
  function automatic rx_stat_e rank_status(input logic dec, input logic disp,
                                           input logic ovf, input logic unf,
                                           input logic add, input logic del);
    if (dec)       return ST_DEC;
    else if (disp) return ST_DISP;
    else if (ovf)  return ST_OVF;
    else if (unf)  return ST_UNF;
    else if (add)  return ST_ADD;
    else if (del)  return ST_DEL;
    else           return ST_OK;
  endfunction

endpackage

// File: rtl/rxeb_ptr_xing.sv
`timescale 1ns/1ps
// Moves a binary pointer that steps by at most one per source cycle
// into another clock domain, as Gray code through two flops.
module rxeb_ptr_xing #(
  parameter int W = 6
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic [W-1:0] src_bin,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_bin
);

  logic [W-1:0] src_gray, meta_q, sync_q;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) src_gray <= '0;
    else            src_gray <= src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= src_gray;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) dst_bin[i] = ^(sync_q >> i);
  end

endmodule

// File: rtl/rxeb_wr_side.sv
`timescale 1ns/1ps
// Write domain: SKP deletion, overflow detection, ring write port.
module rxeb_wr_side
  import rxeb_pkg::*;
#(
  parameter int         DEPTH     = 32,
  parameter int         AW        = 5,
  parameter int         NOM_EMPTY = 4,
  parameter int         THR       = 6,
  parameter logic [7:0] SKP_SYM   = 8'h3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          empty_mode,
  input  logic          in_valid,
  input  logic [7:0]    in_sym,
  input  logic          in_ctrl,
  input  logic          in_dec_err,
  input  logic          in_disp_err,
  input  logic [AW-1:0] rd_pair,   // read pointer in pair units, synchronized
  output logic          we,
  output logic [AW-1:0] waddr,
  output slot_t         wdata,
  output logic [AW:0]   wp,
  output logic [AW:0]   fill
);

  localparam int NOM_HALF = DEPTH / 2;

  logic [AW:0]   nom;
  logic [AW+1:0] del_lvl;
  logic          is_skp, drop_skp, full;
  logic          armed, rm_pend, ovf_pend;

  assign nom      = empty_mode ? (AW+1)'(NOM_EMPTY) : (AW+1)'(NOM_HALF);
  assign del_lvl  = {1'b0, nom} + (AW+2)'(THR);
  // Conservative view: the synchronized read pointer never runs ahead.
  assign fill     = wp - {rd_pair, 1'b0};
  assign is_skp   = in_ctrl && (in_sym == SKP_SYM);
  assign drop_skp = is_skp && armed && ({1'b0, fill} > del_lvl);
  assign full     = fill >= (AW+1)'(DEPTH);
  assign we       = in_valid && !drop_skp && !full;
  assign waddr    = wp[AW-1:0];
  assign wdata    = '{ovf: ovf_pend, rm: rm_pend, dec: in_dec_err,
                      disp: in_disp_err, ctrl: in_ctrl, sym: in_sym};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      armed    <= 1'b1;
      rm_pend  <= 1'b0;
      ovf_pend <= 1'b0;
    end else if (in_valid) begin
      if (drop_skp) begin
        rm_pend <= 1'b1;
        armed   <= 1'b0;
      end else if (full) begin
        ovf_pend <= 1'b1;
      end else begin
        wp       <= wp + 1'b1;
        rm_pend  <= 1'b0;
        ovf_pend <= 1'b0;
        if (!is_skp) armed <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rxeb_rd_side.sv
`timescale 1ns/1ps
// Parallel-clock domain: lock, pair output, SKP insertion, status.
module rxeb_rd_side
  import rxeb_pkg::*;
#(
  parameter int         DEPTH     = 32,
  parameter int         AW        = 5,
  parameter int         NOM_EMPTY = 4,
  parameter int         THR       = 6,
  parameter logic [7:0] SKP_SYM   = 8'h3C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        empty_mode,
  input  logic [AW:0] wq_bin,    // synchronized write pointer
  input  slot_t       e0,        // slot at rp
  input  slot_t       e1,        // slot at rp+1
  output logic [AW:0] rp,
  output logic [AW:0] fill,
  output logic [15:0] rx_data,
  output logic [1:0]  rx_ctrl,
  output logic        rx_valid,
  output logic [2:0]  rx_status
);

  localparam int NOM_HALF = DEPTH / 2;

  logic [AW:0]   nom;
  logic [AW+1:0] ins_lvl;
  logic          locked, armed;
  logic          skp0, skp1, insert, dup;
  slot_t         o1;
  rx_stat_e      pair_stat, ovf_stat;

  assign nom     = empty_mode ? (AW+1)'(NOM_EMPTY) : (AW+1)'(NOM_HALF);
  assign fill    = wq_bin - rp;
  assign ins_lvl = {1'b0, fill} + (AW+2)'(THR);
  assign skp0    = e0.ctrl && (e0.sym == SKP_SYM);
  assign skp1    = e1.ctrl && (e1.sym == SKP_SYM);
  assign insert  = !empty_mode && armed && (ins_lvl < {1'b0, nom}) && (skp0 || skp1);
  // A SKP in the low slot is sent twice in this pair; a SKP in the high
  // slot is left unconsumed so it leads the next pair.
  assign dup     = insert && skp0;
  assign o1      = dup ? e0 : e1;

  assign pair_stat = rank_status(e0.dec | o1.dec, e0.disp | o1.disp, 1'b0, 1'b0,
                                 insert, e0.rm | o1.rm);
  assign ovf_stat  = rank_status(e0.dec | e1.dec, e0.disp | e1.disp, 1'b1, 1'b0,
                                 1'b0, 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp        <= '0;
      locked    <= 1'b0;
      armed     <= 1'b1;
      rx_data   <= '0;
      rx_ctrl   <= '0;
      rx_valid  <= 1'b0;
      rx_status <= ST_OK;
    end else begin
      rx_data   <= '0;
      rx_ctrl   <= '0;
      rx_valid  <= 1'b0;
      rx_status <= ST_OK;
      if (!locked) begin
        if (fill >= nom) locked <= 1'b1;
      end else if (fill < (AW+1)'(2)) begin
        if (!empty_mode) begin
          rx_status <= ST_UNF;
          locked    <= 1'b0;
        end
      end else if (e0.ovf || e1.ovf) begin
        rx_status <= ovf_stat;
        locked    <= 1'b0;
        rp        <= wq_bin;            // flush, regrow to nominal
      end else begin
        rx_valid  <= 1'b1;
        rx_data   <= {o1.sym, e0.sym};
        rx_ctrl   <= {o1.ctrl, e0.ctrl};
        rx_status <= pair_stat;
        rp        <= insert ? rp + 1'b1 : rp + 2'd2;
        if (insert)              armed <= 1'b0;
        else if (!skp0 || !skp1) armed <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rx_elastic_buf.sv
`timescale 1ns/1ps
module rx_elastic_buf
  import rxeb_pkg::*;
#(
  parameter int         DEPTH     = 32,   // power of two
  parameter int         NOM_EMPTY = 4,
  parameter int         THR       = 6,
  parameter logic [7:0] SKP_SYM   = 8'h3C
) (
  input  logic        wr_clk,
  input  logic        wr_rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_sym,
  input  logic        in_ctrl,
  input  logic        in_dec_err,
  input  logic        in_disp_err,
  input  logic        pclk,
  input  logic        p_rst_n,
  input  logic        empty_mode,
  output logic [15:0] rx_data,
  output logic [1:0]  rx_ctrl,
  output logic        rx_valid,
  output logic [2:0]  rx_status
);

  localparam int AW = $clog2(DEPTH);

  slot_t         ring [DEPTH];
  slot_t         wdata, e0, e1;
  logic          we;
  logic [AW-1:0] waddr, raddr0, raddr1, rq_pair;
  logic [AW:0]   wp, rp, wq_bin, wr_fill, rd_fill;

  always_ff @(posedge wr_clk) begin
    if (we) ring[waddr] <= wdata;
  end

  assign raddr0 = rp[AW-1:0];
  assign raddr1 = raddr0 + 1'b1;
  assign e0     = ring[raddr0];
  assign e1     = ring[raddr1];

  rxeb_wr_side #(.DEPTH(DEPTH), .AW(AW), .NOM_EMPTY(NOM_EMPTY), .THR(THR),
                 .SKP_SYM(SKP_SYM)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .empty_mode(empty_mode),
    .in_valid(in_valid), .in_sym(in_sym), .in_ctrl(in_ctrl),
    .in_dec_err(in_dec_err), .in_disp_err(in_disp_err), .rd_pair(rq_pair),
    .we(we), .waddr(waddr), .wdata(wdata), .wp(wp), .fill(wr_fill)
  );

  rxeb_ptr_xing #(.W(AW+1)) u_wp_xing (
    .src_clk(wr_clk), .src_rst_n(wr_rst_n), .src_bin(wp),
    .dst_clk(pclk), .dst_rst_n(p_rst_n), .dst_bin(wq_bin)
  );

  // Pair-unit read pointer steps by at most one per pclk.
  rxeb_ptr_xing #(.W(AW)) u_rp_xing (
    .src_clk(pclk), .src_rst_n(p_rst_n), .src_bin(rp[AW:1]),
    .dst_clk(wr_clk), .dst_rst_n(wr_rst_n), .dst_bin(rq_pair)
  );

  rxeb_rd_side #(.DEPTH(DEPTH), .AW(AW), .NOM_EMPTY(NOM_EMPTY), .THR(THR),
                 .SKP_SYM(SKP_SYM)) u_rd (
    .clk(pclk), .rst_n(p_rst_n), .empty_mode(empty_mode), .wq_bin(wq_bin),
    .e0(e0), .e1(e1), .rp(rp), .fill(rd_fill),
    .rx_data(rx_data), .rx_ctrl(rx_ctrl), .rx_valid(rx_valid), .rx_status(rx_status)
  );

endmodule

// File: rtl/rxeb_checker.sv
`timescale 1ns/1ps
module rxeb_checker #(
  parameter int DEPTH = 32
) (
  input logic                       wr_clk,
  input logic                       wr_rst_n,
  input logic                       pclk,
  input logic                       p_rst_n,
  input logic                       empty_mode,
  input logic [15:0]                rx_data,
  input logic [1:0]                 rx_ctrl,
  input logic                       rx_valid,
  input logic [2:0]                 rx_status,
  input logic [$clog2(DEPTH):0]     wr_fill,
  input logic [$clog2(DEPTH):0]     rd_fill
);

  assert_idle_zero_R2: assert property (@(posedge pclk) disable iff (!p_rst_n)
    !rx_valid |-> (rx_data == 16'h0000 && rx_ctrl == 2'b00));

  assert_no_underflow_empty_R6: assert property (@(posedge pclk) disable iff (!p_rst_n)
    empty_mode |-> rx_status != 3'b110);

  assert_relock_gap_R7: assert property (@(posedge pclk) disable iff (!p_rst_n)
    (rx_status == 3'b101 || rx_status == 3'b110) |=> !rx_valid);

  assert_add_is_valid_R5: assert property (@(posedge pclk) disable iff (!p_rst_n)
    (rx_status == 3'b001) |-> rx_valid);

  assert_wr_fill_bound_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    int'(wr_fill) <= DEPTH);

  assert_rd_fill_bound_R7: assert property (@(posedge pclk) disable iff (!p_rst_n)
    int'(rd_fill) <= DEPTH);

endmodule

bind rx_elastic_buf rxeb_checker #(.DEPTH(DEPTH)) u_rxeb_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .pclk(pclk), .p_rst_n(p_rst_n),
  .empty_mode(empty_mode), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
  .rx_valid(rx_valid), .rx_status(rx_status),
  .wr_fill(wr_fill), .rd_fill(rd_fill)
);

// File: tb/test_rx_elastic_buf.sv
`timescale 1ns/1ps
module test_rx_elastic_buf;

  logic pclk = 1'b0, wr_clk = 1'b0;
  real  wr_half = 5.0;
  always #10 pclk = ~pclk;            // 50 MHz
  always #(wr_half) wr_clk = ~wr_clk;

  logic        wr_rst_n = 1'b0, p_rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ctrl = 1'b0, in_dec = 1'b0, in_disp = 1'b0;
  logic [7:0]  in_sym = '0;
  logic        empty_mode = 1'b0;
  logic [15:0] rx_data;
  logic [1:0]  rx_ctrl;
  logic        rx_valid;
  logic [2:0]  rx_status;

  rx_elastic_buf i_rx_elastic_buf (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_sym(in_sym),
    .in_ctrl(in_ctrl), .in_dec_err(in_dec), .in_disp_err(in_disp),
    .pclk(pclk), .p_rst_n(p_rst_n), .empty_mode(empty_mode),
    .rx_data(rx_data), .rx_ctrl(rx_ctrl), .rx_valid(rx_valid), .rx_status(rx_status)
  );

  int n_cmp = 0, n_bad = 0;
  int cnt_add, cnt_del;
  bit seen_unf, seen_ovf, seen_valid, cmp_en;
  logic [10:0] exp_q[$];   // {dec, disp, ctrl, sym}
  logic [10:0] item;
  logic [7:0]  m_sym;
  logic        m_ctrl, any_dec, any_disp;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic do_reset(input bit mode);
    wr_rst_n = 1'b0; p_rst_n = 1'b0; in_valid = 1'b0;
    empty_mode = mode;
    exp_q.delete();
    repeat (4) @(negedge pclk);
    @(negedge wr_clk); wr_rst_n = 1'b1;
    @(negedge pclk);   p_rst_n = 1'b1;
    cnt_add = 0; cnt_del = 0;
    seen_unf = 0; seen_ovf = 0; seen_valid = 0;
  endtask

  // Driver: SKP sets of four every 36 symbols; non-SKP symbols go to the queue.
  task automatic drive(input int n, input bit skp_on);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      in_valid = 1'b1;
      if (skp_on && (i % 36) >= 32) begin
        in_sym = 8'h3C; in_ctrl = 1'b1; in_dec = 1'b0; in_disp = 1'b0;
      end else begin
        in_ctrl = (i % 13 == 0);
        in_sym  = in_ctrl ? 8'hBC : 8'(i * 7);
        in_dec  = (i % 97 == 5)  || (i % 500 == 250);
        in_disp = (i % 97 == 50) || (i % 500 == 250);
        exp_q.push_back({in_dec, in_disp, in_ctrl, in_sym});
      end
    end
    @(negedge wr_clk);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge pclk) begin
    if (p_rst_n) begin
      if (rx_status == 3'b001) cnt_add++;
      if (rx_status == 3'b010) cnt_del++;
      if (rx_status == 3'b110) seen_unf = 1;
      if (rx_status == 3'b101) seen_ovf = 1;
      if (rx_valid) begin
        seen_valid = 1;
        if (cmp_en) begin
          any_dec = 1'b0; any_disp = 1'b0;
          for (int b = 0; b < 2; b++) begin
            m_sym  = rx_data[8*b +: 8];
            m_ctrl = rx_ctrl[b];
            if (!(m_ctrl && m_sym == 8'h3C)) begin
              if (exp_q.size() == 0) begin
                check(1'b0, "R1", "unexpected symbol", {m_ctrl, m_sym}, -1);
              end else begin
                item = exp_q.pop_front();
                check({m_ctrl, m_sym} == item[8:0], "R1", "symbol/flag in order",
                      {m_ctrl, m_sym}, item[8:0]);
                any_dec  = any_dec | item[10];
                any_disp = any_disp | item[9];
              end
            end
          end
          if (any_dec)
            check(rx_status == 3'b100, "R3", "decode status (wins)", rx_status, 4);
          else if (any_disp)
            check(rx_status == 3'b111, "R3", "disparity status", rx_status, 7);
          else
            check(rx_status <= 3'b010, "R3", "clean pair status", rx_status, 0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge pclk);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    summary();
    $finish;
  end

  initial begin
    cmp_en = 0;
    do_reset(1'b0);
    // R8: reset state (sample while held in reset)
    p_rst_n = 1'b0;
    @(negedge pclk);
    check(rx_valid == 1'b0, "R8", "valid in reset", rx_valid, 0);
    check(rx_data == 16'h0, "R8", "data in reset", rx_data, 0);
    check(rx_ctrl == 2'b0, "R8", "ctrl in reset", rx_ctrl, 0);
    check(rx_status == 3'b0, "R8", "status in reset", rx_status, 0);

    // Half-full mode, fast write clock: deletions, then underflow on stop.
    do_reset(1'b0);
    wr_half = 4.95; cmp_en = 1;
    fork
      drive(3000, 1'b1);
      begin
        repeat (6) begin
          @(negedge pclk);
          check(rx_valid == 1'b0, "R2", "valid before nominal fill", rx_valid, 0);
        end
      end
    join
    repeat (40) @(negedge pclk);
    check(cnt_del > 0, "R4", "SKP removed reports", cnt_del, 1);
    check(seen_unf, "R6", "underflow reported in half mode", seen_unf, 1);
    check(exp_q.size() <= 1, "R1", "symbols left undelivered", exp_q.size(), 0);

    // Half-full mode, slow write clock: insertions.
    do_reset(1'b0);
    wr_half = 5.05;
    drive(3000, 1'b1);
    repeat (40) @(negedge pclk);
    check(cnt_add > 0, "R5", "SKP added reports", cnt_add, 1);
    check(exp_q.size() <= 1, "R1", "symbols left undelivered", exp_q.size(), 0);

    // Nearly-empty mode: early lock, no underflow code on stop.
    do_reset(1'b1);
    wr_half = 5.0;
    fork
      drive(1000, 1'b1);
      begin
        repeat (20) @(negedge pclk);
        check(seen_valid, "R2", "lock at small nominal fill", seen_valid, 1);
      end
    join
    repeat (40) @(negedge pclk);
    check(!seen_unf, "R6", "no underflow code in empty mode", seen_unf, 0);
    check(rx_valid == 1'b0, "R6", "valid low when starved", rx_valid, 0);
    check(exp_q.size() <= 1, "R1", "symbols left undelivered", exp_q.size(), 0);

    // Overload: overflow, flush, relock.
    do_reset(1'b0);
    cmp_en = 0;
    wr_half = 3.0;
    drive(400, 1'b0);
    check(seen_ovf, "R7", "overflow reported", seen_ovf, 1);
    seen_valid = 0;
    wr_half = 5.0;
    drive(800, 1'b1);
    check(seen_valid, "R7", "relock after overflow", seen_valid, 1);

    summary();
    $finish;
  end

endmodule